// File: doc/BRIEF.md
# Asynchronous Byte-Lane SRAM Controller

This block lets a synchronous host reach a 128K x 16 asynchronous static RAM that has one enable for each byte lane. The host offers a request with a 17-bit word address, a 16-bit write word, a 2-bit lane mask and a direction flag. The request is taken when `req_valid` and `req_ready` are both high. A read returns its data with a one-cycle `rsp_valid` pulse. A write returns nothing.

On the memory side the controller drives active-low chip select, write strobe, output strobe and the two lane enables. The bidirectional data bus is split into an outgoing word, an incoming word and a drive enable, which the pad ring joins into a tri-state pin. Each wait count is a whole number of clock cycles, worked out at elaboration as ceiling(time / clock period) from the memory's nanosecond limits:

- The read count comes from the read cycle time and the address-to-data time.
- The write count comes from the write cycle time, the strobe pulse width, the address setup time and the data setup time.
- The turnaround count comes from the time the memory may keep driving the bus after its output strobe rises.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all five memory strobes are high, `mem_dq_oe` is low, `req_ready` is high and `rsp_valid` is low.
- R2: A read with a nonzero mask holds chip select low, output strobe low and write strobe high for exactly RD_CYC cycles, where RD_CYC = ceiling(max(70, 70) / 10) = 7 with default parameters. Mask bit 0 enables the lower lane (data bits 7:0, `mem_lb_n` low). Mask bit 1 enables the upper lane (data bits 15:8, `mem_ub_n` low).
- R3: `rsp_valid` is high for one cycle, RD_CYC + 1 cycles after the accepting edge. `rsp_rdata` carries the bus value sampled in the last strobe cycle, with each disabled lane returned as zero.
- R4: A write with a nonzero mask holds chip select and write strobe low for exactly WR_CYC cycles, where WR_CYC = ceiling(max(70, 50, 60, 30) / 10) = 7. During those cycles the output strobe stays high and `mem_dq_oe` is high with the request's data on `mem_dq_o`.
- R5: Throughout an access, the address, lane enables and outgoing data equal the accepted request and do not change.
- R6: `mem_dq_oe` is never high while the output strobe is low. After the output strobe rises, `mem_dq_oe` stays low for at least TA_CYC = ceiling(25 / 10) = 3 cycles.
- R7: `req_ready` falls at acceptance and stays low for RD_CYC + TA_CYC cycles after a read and WR_CYC cycles after a write. Chip select is high whenever `req_ready` is high.
- R8: A request with mask 00 never lowers chip select and leaves `req_ready` high. As a read, it gives `rsp_valid` with data 0 in the next cycle. As a write, it gives no response and changes no memory word.
- R9: A partial write changes only its enabled lane, so a later full read returns the old value in the other lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write word |
| req_bmask | input | 2 | Lane mask, bit 0 lower, bit 1 upper |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_dq_o | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_in | input | 16 | Data received from memory |

## Verification
The assertions check the following on every cycle:

- the strobe combinations allowed in reads and writes;
- the exact strobe widths;
- the no-drive gap after the output strobe rises, and that the two sides never drive the bus together;
- that address, lanes and outgoing data stay frozen during an access;
- that chip select stays high while idle and is never lowered by an empty mask.

Some behaviour only the bench's scenarios can show. These are:

- that the returned word is the one stored by earlier partial or full writes;
- that disabled lanes read back as zero;
- the response latency and the length of the ready gap.

For these, a memory model in the bench returns garbage until the address-to-data time has passed.

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int CLK_NS = 10,
  parameter int T_RC   = 70,
  parameter int T_AA   = 70,
  parameter int T_WC   = 70,
  parameter int T_PWE  = 50,
  parameter int T_AW   = 60,
  parameter int T_SD   = 30,
  parameter int T_HZ   = 25,
  parameter int AW     = 17,
  parameter int DW     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_bmask,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_lb_n,
  output logic          mem_ub_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int LW      = DW / 2;
  localparam int RD_NS   = (T_RC > T_AA) ? T_RC : T_AA;
  localparam int WA_NS   = (T_WC > T_PWE) ? T_WC : T_PWE;
  localparam int WB_NS   = (T_AW > T_SD) ? T_AW : T_SD;
  localparam int WR_NS   = (WA_NS > WB_NS) ? WA_NS : WB_NS;
  localparam int RD_CYC  = (RD_NS + CLK_NS - 1) / CLK_NS;
  localparam int WR_CYC  = (WR_NS + CLK_NS - 1) / CLK_NS;
  localparam int TA_CYC  = (T_HZ + CLK_NS - 1) / CLK_NS;
  localparam int MX_A    = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int CNT_MAX = (MX_A > TA_CYC) ? MX_A : TA_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE, S_TURN} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q;
  logic [1:0]    bm_q;
  logic [DW-1:0] lane_mask;

  assign lane_mask = {{LW{bm_q[1]}}, {LW{bm_q[0]}}};
  assign req_ready = (st == S_IDLE);
  assign mem_ce_n  = !(st == S_READ || st == S_WRITE);
  assign mem_oe_n  = (st != S_READ);
  assign mem_we_n  = (st != S_WRITE);
  assign mem_lb_n  = mem_ce_n | ~bm_q[0];
  assign mem_ub_n  = mem_ce_n | ~bm_q[1];
  assign mem_addr  = a_q;
  assign mem_dq_o  = d_q;
  assign mem_dq_oe = (st == S_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      a_q       <= '0;
      d_q       <= '0;
      bm_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          a_q  <= req_addr;
          d_q  <= req_wdata;
          bm_q <= req_bmask;
          if (req_bmask == 2'b00) begin
            if (!req_we) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= '0;
            end
          end else if (req_we) begin
            st  <= S_WRITE;
            cnt <= CW'(WR_CYC - 1);
          end else begin
            st  <= S_READ;
            cnt <= CW'(RD_CYC - 1);
          end
        end
        S_READ: if (cnt == '0) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= mem_dq_in & lane_mask;
          st        <= (TA_CYC > 0) ? S_TURN : S_IDLE;
          cnt       <= CW'((TA_CYC > 0) ? TA_CYC - 1 : 0);
        end else cnt <= cnt - 1'b1;
        S_WRITE, S_TURN: if (cnt == '0) st <= S_IDLE;
                         else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int RD_CYC = 7,
  parameter int WR_CYC = 7,
  parameter int TA_CYC = 3,
  parameter int AW     = 17,
  parameter int DW     = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_bmask,
  input logic          rsp_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic          mem_lb_n,
  input logic          mem_ub_n,
  input logic [DW-1:0] mem_dq_o,
  input logic          mem_dq_oe
);
  logic [7:0] we_run, oe_run, since_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run   <= '0;
      oe_run   <= '0;
      since_oe <= 8'hFF;
    end else begin
      we_run   <= !mem_we_n ? ((we_run == 8'hFF) ? we_run : we_run + 1'b1) : 8'h0;
      oe_run   <= !mem_oe_n ? ((oe_run == 8'hFF) ? oe_run : oe_run + 1'b1) : 8'h0;
      since_oe <= !mem_oe_n ? 8'h0 : ((since_oe == 8'hFF) ? since_oe : since_oe + 1'b1);
    end
  end

  p_read_strobes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n && !(mem_lb_n && mem_ub_n)));
  p_read_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_run == 8'(RD_CYC)));
  p_rsp_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> rsp_valid);
  p_write_strobes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe && !(mem_lb_n && mem_ub_n)));
  p_write_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run == 8'(WR_CYC)));
  p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |->
      ($stable(mem_addr) && $stable(mem_lb_n) && $stable(mem_ub_n) && $stable(mem_dq_o)));
  p_no_fight_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));
  p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (since_oe >= 8'(TA_CYC)));
  p_idle_deselect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_ce_n);
  p_empty_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_bmask == 2'b00) |=> (mem_ce_n && req_ready));
endmodule

bind sram_ctrl sram_ctrl_chk #(
  .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .TA_CYC(TA_CYC), .AW(AW), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_bmask(req_bmask), .rsp_valid(rsp_valid), .mem_addr(mem_addr),
  .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_o(mem_dq_o),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_ctrl_test.sv
`timescale 1ns/1ps
module sram_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int RD = 7;
  localparam int WR = 7;
  localparam int TA = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_bmask = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] rsp_rdata, mem_dq_o, mem_dq_in;
  logic [16:0] mem_addr;

  sram_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_bmask(req_bmask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] init_val(input int i);
    return 16'(i * 16'h0101) ^ 16'h3C96;
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw, input logic [1:0] m);
    return {m[1] ? nw[15:8] : old[15:8], m[0] ? nw[7:0] : old[7:0]};
  endfunction

  function automatic logic [15:0] lanes(input logic [15:0] w, input logic [1:0] m);
    return {m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00};
  endfunction

  // memory model: garbage until the address-to-data time has passed
  logic [15:0] mdl [256];
  logic [15:0] exp_mem [256];
  int rd_age = 0;
  logic rd_act;
  assign rd_act = !mem_ce_n && !mem_oe_n && mem_we_n;

  always @(posedge clk) rd_age <= rd_act ? rd_age + 1 : 0;

  always_comb begin
    logic [15:0] w;
    w = mdl[mem_addr[7:0]];
    mem_dq_in[7:0]  = (rd_act && !mem_lb_n) ? ((rd_age >= RD-1) ? w[7:0]  : 8'h5A) : 8'hEE;
    mem_dq_in[15:8] = (rd_act && !mem_ub_n) ? ((rd_age >= RD-1) ? w[15:8] : 8'hA5) : 8'hEE;
  end

  always @(negedge clk) if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
    if (!mem_lb_n) mdl[mem_addr[7:0]][7:0]  <= mem_dq_o[7:0];
    if (!mem_ub_n) mdl[mem_addr[7:0]][15:8] <= mem_dq_o[15:8];
  end

  // bus monitor
  logic [16:0] cur_addr = '0;
  logic [15:0] cur_data = '0;
  logic [1:0]  cur_mask = '0;
  bit mon_on = 0;
  int we_run = 0, oe_run = 0, since_oe = 100;
  logic dq_oe_prev = 1'b0;

  always @(negedge clk) if (mon_on) begin
    if (!mem_we_n) we_run++;
    else if (we_run != 0) begin
      chk(we_run == WR, "R4 write strobe width", we_run, WR);
      we_run = 0;
    end
    if (!mem_oe_n) begin
      oe_run++;
      chk(!mem_ce_n && mem_we_n, "R2 read strobe levels", {mem_ce_n, mem_we_n}, 2'b01);
    end else if (oe_run != 0) begin
      chk(oe_run == RD, "R2 read strobe width", oe_run, RD);
      oe_run = 0;
    end
    if (mem_dq_oe && !dq_oe_prev)
      chk(since_oe >= TA, "R6 turnaround gap", since_oe, TA);
    chk(!(mem_dq_oe && !mem_oe_n), "R6 bus contention", {mem_dq_oe, mem_oe_n}, 2'b01);
    since_oe = !mem_oe_n ? 0 : since_oe + 1;
    dq_oe_prev = mem_dq_oe;
    if (!mem_ce_n) begin
      chk(mem_addr == cur_addr, "R5 address held", mem_addr, cur_addr);
      chk({mem_ub_n, mem_lb_n} == ~cur_mask, "R2 R5 lane enables", {mem_ub_n, mem_lb_n}, ~cur_mask);
      if (mem_dq_oe) chk(mem_dq_o == cur_data, "R4 R5 write data", mem_dq_o, cur_data);
    end
    if (req_ready) chk(mem_ce_n, "R7 deselected when idle", mem_ce_n, 1);
  end

  task automatic do_req(input logic we, input logic [16:0] addr, input logic [15:0] data, input logic [1:0] m);
    int low, rsp_at;
    logic [15:0] got;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_addr = addr; cur_data = data; cur_mask = m;
    req_valid = 1'b1; req_we = we; req_addr = addr; req_wdata = data; req_bmask = m;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    low = 0; rsp_at = 0; got = '0;
    for (int i = 1; i < 40; i++) begin
      if (m == 2'b00) chk(mem_ce_n, "R8 no select on empty mask", mem_ce_n, 1);
      if (rsp_valid) begin
        if (rsp_at != 0) chk(0, "R3 single response pulse", i, rsp_at);
        rsp_at = i; got = rsp_rdata;
      end
      if (req_ready) break;
      low++;
      @(negedge clk);
    end
    if (we) begin
      chk(low == ((m == 0) ? 0 : WR), "R7 write busy length", low, (m == 0) ? 0 : WR);
      chk(rsp_at == 0, "R8 no response to write", rsp_at, 0);
      exp_mem[addr[7:0]] = merge(exp_mem[addr[7:0]], data, m);
    end else begin
      chk(low == ((m == 0) ? 0 : RD + TA), "R7 read busy length", low, (m == 0) ? 0 : RD + TA);
      chk(rsp_at == ((m == 0) ? 1 : RD + 1), "R3 response latency", rsp_at, (m == 0) ? 1 : RD + 1);
      chk(got == lanes(exp_mem[addr[7:0]], m), "R3 R9 read data", got, lanes(exp_mem[addr[7:0]], m));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      chk(0, "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    for (int i = 0; i < 256; i++) begin
      mdl[i] = init_val(i);
      exp_mem[i] = init_val(i);
    end
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    chk({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n} == 5'h1F, "R1 strobes in reset",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 5'h1F);
    chk(!mem_dq_oe && !rsp_valid, "R1 drive and response off", {mem_dq_oe, rsp_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && mem_ce_n && !mem_dq_oe, "R1 idle after reset", {req_ready, mem_ce_n, mem_dq_oe}, 3'b110);
    mon_on = 1;

    do_req(1, 17'h1FFFF, 16'hA5C3, 2'b11);
    do_req(0, 17'h1FFFF, 16'h0000, 2'b11);
    do_req(1, 17'h00000, 16'h1234, 2'b01);
    do_req(0, 17'h00000, 16'h0000, 2'b11);
    do_req(0, 17'h00000, 16'h0000, 2'b10);
    do_req(1, 17'h00000, 16'hBEEF, 2'b10);
    do_req(0, 17'h00000, 16'h0000, 2'b01);
    do_req(0, 17'h00000, 16'h0000, 2'b11);
    do_req(1, 17'h00040, 16'hFFFF, 2'b00);
    do_req(0, 17'h00040, 16'h0000, 2'b11);
    do_req(0, 17'h00040, 16'h0000, 2'b00);
    do_req(0, 17'h00041, 16'h0000, 2'b11);
    do_req(1, 17'h00041, 16'h5555, 2'b11);
    do_req(1, 17'h00042, 16'h6666, 2'b11);

    for (int k = 0; k < 400; k++) begin
      logic [16:0] a;
      a = 17'($urandom);
      do_req(1'($urandom), a, 16'($urandom), 2'($urandom));
    end
    for (int i = 0; i < 256; i += 17) do_req(0, 17'(i), 16'h0, 2'b11);

    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule